// File: doc/BRIEF.md
# Receive Queue and Interrupt Combiner

This block takes characters from an upstream serial receive shifter, which has already framed them, and holds them for a register-style reader. Each arriving character comes with its data byte, a framing-error bit, a parity-error bit and, on a separate strobe, a line-break indication. Two storage paths exist. In the default single-holding-register mode, each new character overwrites one buffer. In queue mode, characters go into a first-in first-out store, and each slot keeps its two error bits beside the data byte.

The reader sees the oldest held character on the read-data outputs. It consumes that character by pulsing the read strobe. A single interrupt line merges three kinds of event: character available or break seen, character error, and queue overflow. The first kind is gated by one enable input and the other two by a second enable input. A soft-reset input empties the queue and clears its overflow state at any time, and a clear pulse removes the sticky overflow flag.

Top module: `rx_fifo_irq_unit`

## Requirements
- R1: After reset the block is in single-holding-register mode with fill level 0, all flags low and the interrupt low. Whenever the queue-enable input is low, the fill level reads 0 and queue contents and overflow do not affect any output.
- R2: In single-holding-register mode a character strobe loads the holding register and raises rx_ready on the next cycle. A read strobe with no character strobe lowers rx_ready on the next cycle. The overflow clear input has no visible effect.
- R3: In queue mode, rd_data shows the oldest stored character with its framing bit on rd_frame_err and its parity bit on rd_parity_err. A read strobe removes that character, so characters leave in arrival order.
- R4: fill_level reports the number of stored characters, from 0 up to the depth of 16.
- R5: A character arriving while the queue holds 16 characters is discarded, leaving contents and fill level unchanged, and sets ovf_flag.
- R6: ovf_flag stays set until a pulse on the overflow clear input or a soft reset.
- R7: While soft reset is high, the queue is emptied, ovf_flag is cleared, and arriving characters are not stored.
- R8: rx_irq is raised by rx_ready or brk_flag only while rdy_brk_ie is 1.
- R9: rx_err_flag is 1 when the held or oldest character has a framing or parity error, or when ovf_flag is set. rx_irq follows it only while err_ie is 1.
- R10: A pulse on rx_break sets brk_flag on the next cycle. A read strobe clears it.
- R11: A read strobe on an empty queue leaves the fill level at 0 and does not corrupt later storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a framed character is present |
| rx_data | input | 8 | Received data byte |
| rx_frame_err | input | 1 | Framing error for the present character |
| rx_parity_err | input | 1 | Parity error for the present character |
| rx_break | input | 1 | One-cycle strobe: break condition detected |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| fifo_srst | input | 1 | Soft reset of the queue, active high |
| ovf_clr | input | 1 | Pulse to clear the sticky overflow flag |
| rd_en | input | 1 | Read strobe of the data register |
| rdy_brk_ie | input | 1 | Enable for ready and break interrupts |
| err_ie | input | 1 | Enable for error and overflow interrupts |
| rd_data | output | 8 | Oldest or held data byte |
| rd_frame_err | output | 1 | Framing bit stored with rd_data |
| rd_parity_err | output | 1 | Parity bit stored with rd_data |
| rx_ready | output | 1 | A character is available |
| brk_flag | output | 1 | Break seen since last read |
| rx_err_flag | output | 1 | Error on the offered character, or overflow |
| ovf_flag | output | 1 | Sticky queue overflow |
| fill_level | output | 5 | Number of stored characters |
| rx_irq | output | 1 | Combined receive interrupt |

## Verification
The hardest state to reach is a full queue that then receives one more character. Reaching it takes exactly sixteen accepted strobes with no reads in between, and the discarded character is only visible indirectly. The bench fills the queue with numbered bytes, sends a distinct extra byte, and then checks three things: the flag, the unchanged level, and the fact that draining produces exactly the numbered bytes. It also repeats the overflow and then applies soft reset, to show that the sticky flag is cleared only through that route or through the clear pulse.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    parameter int unsigned RXQ_DATA_W = 8;

    typedef struct packed {
        logic                  frame_err;
        logic                  parity_err;
        logic [RXQ_DATA_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic          ovf_clr,
    input  rxq_entry_t    wr_entry,
    output rxq_entry_t    head,
    output logic [CW-1:0] count,
    output logic          ovf
);
    typedef struct packed {
        rxq_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]          wr_ptr;
        logic [AW-1:0]          rd_ptr;
        logic [CW-1:0]          cnt;
        logic                   ovf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic full, empty, do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;

        if (do_push) begin
            st_d.mem[st_q.wr_ptr] = wr_entry;
            st_d.wr_ptr = (st_q.wr_ptr == AW'(DEPTH - 1)) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == AW'(DEPTH - 1)) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase

        if (ovf_clr)      st_d.ovf = 1'b0;
        if (push && full) st_d.ovf = 1'b1;

        if (clr) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
            st_d.ovf    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd_ptr];
    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;

    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && push && !pop && st_q.cnt == CW'(DEPTH))
        |=> (st_q.cnt == CW'(DEPTH) && st_q.ovf));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ovf_clr && st_q.ovf) |=> st_q.ovf);

    a_r7_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && !st_q.ovf));

    a_r11_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && pop && !push && st_q.cnt == '0) |=> (st_q.cnt == '0));
endmodule

// File: rtl/rxq_legacy.sv
module rxq_legacy
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       rd,
    input  rxq_entry_t in_entry,
    output rxq_entry_t held,
    output logic       ready
);
    typedef struct packed {
        rxq_entry_t hold;
        logic       rdy;
    } leg_state_t;

    leg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) st_d.rdy = 1'b0;
        if (load) begin
            st_d.hold = in_entry;
            st_d.rdy  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held  = st_q.hold;
    assign ready = st_q.rdy;

    a_r2_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> st_q.rdy);

    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> !st_q.rdy);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_set,
    input  logic brk_clr,
    input  logic ready,
    input  logic err,
    input  logic rdy_brk_ie,
    input  logic err_ie,
    output logic brk_flag,
    output logic irq
);
    typedef struct packed {
        logic brk;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (brk_clr) st_d.brk = 1'b0;
        if (brk_set) st_d.brk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk_flag = st_q.brk;
    assign irq      = (rdy_brk_ie && (ready || st_q.brk)) || (err_ie && err);

    a_r10_brk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr && !brk_set) |=> !st_q.brk);

    a_r10_brk_set: assert property (@(posedge clk) disable iff (!rst_n)
        brk_set |=> st_q.brk);

    a_r8_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_brk_ie && !err_ie) |-> !irq);
endmodule

// File: rtl/rx_fifo_irq_unit.sv
module rx_fifo_irq_unit
    import rxq_pkg::*;
#(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [RXQ_DATA_W-1:0] rx_data,
    input  logic                  rx_frame_err,
    input  logic                  rx_parity_err,
    input  logic                  rx_break,
    input  logic                  fifo_en,
    input  logic                  fifo_srst,
    input  logic                  ovf_clr,
    input  logic                  rd_en,
    input  logic                  rdy_brk_ie,
    input  logic                  err_ie,
    output logic [RXQ_DATA_W-1:0] rd_data,
    output logic                  rd_frame_err,
    output logic                  rd_parity_err,
    output logic                  rx_ready,
    output logic                  brk_flag,
    output logic                  rx_err_flag,
    output logic                  ovf_flag,
    output logic [LVL_W-1:0]      fill_level,
    output logic                  rx_irq
);
    rxq_entry_t in_entry, q_head, l_held, shown;
    logic [LVL_W-1:0] q_count;
    logic q_ovf, q_active, q_clr, l_ready, q_nonempty;

    assign in_entry = '{frame_err: rx_frame_err, parity_err: rx_parity_err, data: rx_data};
    assign q_active = fifo_en && !fifo_srst;
    assign q_clr    = !fifo_en || fifo_srst;

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (q_clr),
        .push     (q_active && rx_valid),
        .pop      (q_active && rd_en),
        .ovf_clr  (ovf_clr),
        .wr_entry (in_entry),
        .head     (q_head),
        .count    (q_count),
        .ovf      (q_ovf)
    );

    rxq_legacy u_legacy (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (!fifo_en && rx_valid),
        .rd       (!fifo_en && rd_en),
        .in_entry (in_entry),
        .held     (l_held),
        .ready    (l_ready)
    );

    always_comb begin
        q_nonempty = (q_count != '0);
        if (fifo_en) begin
            shown       = q_head;
            rx_ready    = q_nonempty;
            ovf_flag    = q_ovf;
            fill_level  = q_count;
            rx_err_flag = (q_nonempty && (q_head.frame_err || q_head.parity_err)) || q_ovf;
        end else begin
            shown       = l_held;
            rx_ready    = l_ready;
            ovf_flag    = 1'b0;
            fill_level  = '0;
            rx_err_flag = l_ready && (l_held.frame_err || l_held.parity_err);
        end
    end

    assign rd_data       = shown.data;
    assign rd_frame_err  = shown.frame_err;
    assign rd_parity_err = shown.parity_err;

    rxq_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .brk_set    (rx_break),
        .brk_clr    (rd_en),
        .ready      (rx_ready),
        .err        (rx_err_flag),
        .rdy_brk_ie (rdy_brk_ie),
        .err_ie     (err_ie),
        .brk_flag   (brk_flag),
        .irq        (rx_irq)
    );

    a_r1_legacy_level: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (fill_level == '0 && !ovf_flag));
endmodule

// File: tb/tb_rx_fifo_irq_unit.sv
module tb_rx_fifo_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid, rx_frame_err, rx_parity_err, rx_break;
    logic [7:0] rx_data;
    logic       fifo_en, fifo_srst, ovf_clr, rd_en, rdy_brk_ie, err_ie;
    logic [7:0] rd_data;
    logic       rd_frame_err, rd_parity_err, rx_ready, brk_flag, rx_err_flag, ovf_flag, rx_irq;
    logic [4:0] fill_level;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    rx_fifo_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err), .rx_break(rx_break),
        .fifo_en(fifo_en), .fifo_srst(fifo_srst), .ovf_clr(ovf_clr), .rd_en(rd_en),
        .rdy_brk_ie(rdy_brk_ie), .err_ie(err_ie), .rd_data(rd_data),
        .rd_frame_err(rd_frame_err), .rd_parity_err(rd_parity_err), .rx_ready(rx_ready),
        .brk_flag(brk_flag), .rx_err_flag(rx_err_flag), .ovf_flag(ovf_flag),
        .fill_level(fill_level), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic fe, input logic pe);
        rx_data = d; rx_frame_err = fe; rx_parity_err = pe; rx_valid = 1'b1;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    endtask

    task automatic rd_pulse();
        rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset fill", fill_level, 0);
        chk("R1 reset ready", rx_ready, 0);
        chk("R1 reset ovf", ovf_flag, 0);
        chk("R1 reset irq", rx_irq, 0);
    endtask

    task automatic t_legacy();
        send(8'hA5, 1'b1, 1'b0);
        chk("R2 legacy ready", rx_ready, 1);
        chk("R2 legacy data", {rd_frame_err, rd_parity_err, rd_data}, {2'b10, 8'hA5});
        chk("R1 legacy fill", fill_level, 0);
        err_ie = 1'b1; #1;
        chk("R9 legacy error irq", rx_irq, 1);
        err_ie = 1'b0;
        ovf_clr = 1'b1; @(posedge clk); #1; ovf_clr = 1'b0;
        chk("R2 ovf_clr no effect", {rx_ready, fill_level}, {1'b1, 5'd0});
        rd_pulse();
        chk("R2 read clears ready", rx_ready, 0);
    endtask

    task automatic t_fifo_order();
        fifo_en = 1'b1;
        @(posedge clk); #1;
        for (int i = 0; i < 16; i++) send(8'h30 + 8'(i), i[0], i[1]);
        chk("R4 full level", fill_level, 16);
        for (int i = 0; i < 16; i++) begin
            chk("R3 order", {rd_frame_err, rd_parity_err, rd_data}, {i[0], i[1], 8'h30 + 8'(i)});
            rd_pulse();
        end
        chk("R4 drained level", fill_level, 0);
    endtask

    task automatic t_overflow();
        err_ie = 1'b1;
        for (int i = 0; i < 16; i++) send(8'(i), 1'b0, 1'b0);
        chk("R9 no error irq", rx_irq, 0);
        send(8'hEE, 1'b0, 1'b0);
        chk("R5 level held", fill_level, 16);
        chk("R5 ovf set", ovf_flag, 1);
        chk("R9 ovf irq", {rx_err_flag, rx_irq}, 2'b11);
        repeat (3) @(posedge clk); #1;
        chk("R6 ovf sticky", ovf_flag, 1);
        ovf_clr = 1'b1; @(posedge clk); #1; ovf_clr = 1'b0;
        chk("R6 ovf cleared", {ovf_flag, rx_irq}, 2'b00);
        for (int i = 0; i < 16; i++) begin
            chk("R5 contents kept", rd_data, i);
            rd_pulse();
        end
        chk("R5 nothing extra", fill_level, 0);
        err_ie = 1'b0;
    endtask

    task automatic t_srst();
        for (int i = 0; i < 17; i++) send(8'h50 + 8'(i), 1'b0, 1'b0);
        chk("R5 ovf before srst", ovf_flag, 1);
        fifo_srst = 1'b1;
        send(8'h99, 1'b0, 1'b0);
        chk("R7 srst empties", {ovf_flag, fill_level}, {1'b0, 5'd0});
        fifo_srst = 1'b0;
        send(8'h77, 1'b0, 1'b1);
        chk("R7 after srst", {fill_level, rd_parity_err, rd_data}, {5'd1, 1'b1, 8'h77});
        rd_pulse();
    endtask

    task automatic t_irq();
        send(8'h11, 1'b0, 1'b0);
        chk("R8 ready without enable", {rx_ready, rx_irq}, 2'b10);
        rdy_brk_ie = 1'b1; #1;
        chk("R8 ready irq", rx_irq, 1);
        rd_pulse();
        chk("R8 irq drops", rx_irq, 0);
        rdy_brk_ie = 1'b0; err_ie = 1'b1;
        send(8'h22, 1'b1, 1'b0);
        chk("R9 entry error irq", {rx_err_flag, rx_irq}, 2'b11);
        rd_pulse();
        chk("R9 error gone", {rx_err_flag, rx_irq}, 2'b00);
        err_ie = 1'b0;
    endtask

    task automatic t_break();
        rdy_brk_ie = 1'b1;
        rx_break = 1'b1; @(posedge clk); #1; rx_break = 1'b0;
        chk("R10 break set", {brk_flag, rx_irq, fill_level}, {2'b11, 5'd0});
        rd_pulse();
        chk("R10 break cleared", {brk_flag, rx_irq}, 2'b00);
        chk("R11 empty read level", fill_level, 0);
        rdy_brk_ie = 1'b0;
        rd_pulse();
        send(8'h3C, 1'b0, 1'b0);
        chk("R11 storage intact", {fill_level, rd_data}, {5'd1, 8'h3C});
        rd_pulse();
    endtask

    task automatic t_disable();
        for (int i = 0; i < 17; i++) send(8'(i), 1'b0, 1'b0);
        fifo_en = 1'b0; #1;
        chk("R1 disabled level", {fill_level, ovf_flag, rx_ready}, {5'd0, 2'b00});
        @(posedge clk); #1;
        fifo_en = 1'b1; #1;
        chk("R1 queue cleared when off", {fill_level, ovf_flag}, {5'd0, 1'b0});
    endtask

    initial begin
        rst_n = 1'b0; rx_valid = 0; rx_data = 0; rx_frame_err = 0; rx_parity_err = 0;
        rx_break = 0; fifo_en = 0; fifo_srst = 0; ovf_clr = 0; rd_en = 0;
        rdy_brk_ie = 0; err_ie = 0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_legacy();
        t_fifo_order();
        t_overflow();
        t_srst();
        t_irq();
        t_break();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule